// File: doc/BRIEF.md
# PFC Supervisory State Sequencer

This block is the supervisory controller of a digitally controlled boost power factor correction stage. After reset it waits out a fixed initialization period with the switch drive disabled. It then checks the mains voltage. Only once the mains has been judged acceptable does it enable switching, first in a start-up phase and then in regulated operation. Voltage measurements reach it as sampled values with a valid strobe, and it compares them against threshold inputs. Overcurrent, on-time saturation and downstream ballast errors arrive as single-bit flags.

Any fault sends the sequencer into a latched stop with the drive disabled. The stop records the cause and holds it. The stop does not end when the fault condition goes away. It ends only when a lamp reinsertion is signalled, or when the mains is seen to vanish for a programmable run of samples and then come back. The block reports its state and the recorded fault cause as two small codes.

Top module: `pfc_supervisor`

## Requirements
- R1: After reset, state_code is 0 (init), fault_code is 0 and pwm_en is 0. The state stays 0 for INIT_CYCLES clock edges and then becomes 1 (mains check).
- R2: In the mains check (state 1), pwm_en stays 0. A sample with vin_valid high that lies between vin_lo_th and vin_hi_th inclusive moves the state to 2 (start-up) at the next edge, and pwm_en becomes 1. A sample below vin_lo_th leaves the state at 1.
- R3: In the mains check, a valid sample above vin_hi_th moves the state to 4 (stopped) with fault_code 2 (mains too high).
- R4: In states 2 and 3, ocp_flag forces pwm_en to 0 in the same cycle. At the next edge the state becomes 4 with fault_code 1.
- R5: In start-up, the first valid bus sample inside [bus_lo_th, bus_hi_th] moves the state to 3 (running). A sample below bus_lo_th keeps start-up. A sample above bus_hi_th stops with fault_code 3.
- R6: In running, a valid bus sample above bus_hi_th stops with fault_code 3, and one below bus_lo_th stops with fault_code 4.
- R7: In states 2 and 3, a valid mains sample above vin_hi_th stops with fault_code 2.
- R8: In states 2 and 3, ton_sat_err stops with fault_code 5 and ballast_err stops with fault_code 6.
- R9: When several faults occur in the same cycle, the lowest fault code wins: 1, then 2, 3, 4, 5, 6.
- R10: In state 4, pwm_en is 0, and the state and fault_code are held even after every fault input has cleared.
- R11: lamp_insert high in state 4 moves the state to 0 at the next edge and clears fault_code to 0. In any other state lamp_insert has no effect.
- R12: In state 4, recycle_len consecutive valid mains samples below vin_gone_th mark the mains as lost (a recycle_len of 0 acts as 1). A later valid sample at or above vin_lo_th then moves the state to 0 with fault_code 0. A valid sample at or above vin_gone_th before the run is complete restarts the count, and an accepted sample without a lost mark leaves the stop in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_valid | input | 1 | Mains sample strobe |
| vin_sample | input | SAMP_W | Rectified mains sample |
| vbus_valid | input | 1 | Bus sample strobe |
| vbus_sample | input | SAMP_W | DC bus sample |
| vin_lo_th | input | SAMP_W | Lowest acceptable mains sample |
| vin_hi_th | input | SAMP_W | Highest acceptable mains sample |
| vin_gone_th | input | SAMP_W | Level below which the mains counts as absent |
| bus_lo_th | input | SAMP_W | Lower edge of the bus window |
| bus_hi_th | input | SAMP_W | Upper edge of the bus window |
| recycle_len | input | RCNT_W | Absent-mains samples needed to count as a disconnect |
| ocp_flag | input | 1 | Switch overcurrent comparator output |
| ton_sat_err | input | 1 | On-time saturation error from the regulator |
| ballast_err | input | 1 | Error from the lamp-control side |
| lamp_insert | input | 1 | Lamp reinsertion pulse |
| pwm_en | output | 1 | Switch drive enable |
| state_code | output | 3 | 0 init, 1 mains check, 2 start-up, 3 running, 4 stopped |
| fault_code | output | 3 | 0 none, 1 overcurrent, 2 mains high, 3 bus high, 4 bus low, 5 on-time saturation, 6 ballast error |

## Verification
The hardest situation to reach is the recovery through a mains recycle. It needs a latched stop, then an exact run of absent-mains strobes, and then an accepted sample. The stimulus first breaks a partial run with a mid-level sample. It then offers an acceptable sample too early and confirms that the stop remains. Only after that does it complete the run and show the return to init. Same-cycle fault pairs are driven on a single strobe to pin down the priority order.

// File: rtl/pfc_supervisor.sv
module pfc_supervisor #(
  parameter int SAMP_W      = 10,
  parameter int INIT_CYCLES = 16,
  parameter int RCNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vin_valid,
  input  logic [SAMP_W-1:0] vin_sample,
  input  logic              vbus_valid,
  input  logic [SAMP_W-1:0] vbus_sample,
  input  logic [SAMP_W-1:0] vin_lo_th,
  input  logic [SAMP_W-1:0] vin_hi_th,
  input  logic [SAMP_W-1:0] vin_gone_th,
  input  logic [SAMP_W-1:0] bus_lo_th,
  input  logic [SAMP_W-1:0] bus_hi_th,
  input  logic [RCNT_W-1:0] recycle_len,
  input  logic              ocp_flag,
  input  logic              ton_sat_err,
  input  logic              ballast_err,
  input  logic              lamp_insert,
  output logic              pwm_en,
  output logic [2:0]        state_code,
  output logic [2:0]        fault_code
);

  localparam int ICW = $clog2(INIT_CYCLES + 1);

  localparam logic [2:0] ST_INIT  = 3'd0;
  localparam logic [2:0] ST_CHECK = 3'd1;
  localparam logic [2:0] ST_START = 3'd2;
  localparam logic [2:0] ST_RUN   = 3'd3;
  localparam logic [2:0] ST_ERR   = 3'd4;

  localparam logic [2:0] F_NONE = 3'd0;
  localparam logic [2:0] F_OCP  = 3'd1;
  localparam logic [2:0] F_VIN  = 3'd2;
  localparam logic [2:0] F_BHI  = 3'd3;
  localparam logic [2:0] F_BLO  = 3'd4;
  localparam logic [2:0] F_TON  = 3'd5;
  localparam logic [2:0] F_BAL  = 3'd6;

  logic [2:0]        state_q, state_d;
  logic [2:0]        fault_q, fault_d;
  logic [ICW-1:0]    icnt_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic              lost_q;
  logic [2:0]        fault_sel;

  wire switching = (state_q == ST_START) || (state_q == ST_RUN);
  wire vin_over  = vin_valid && (vin_sample > vin_hi_th);
  wire vin_acc   = vin_valid && (vin_sample >= vin_lo_th);
  wire vin_inwin = vin_acc && !vin_over;
  wire vin_low   = vin_valid && (vin_sample < vin_gone_th);
  wire bus_over  = vbus_valid && (vbus_sample > bus_hi_th);
  wire bus_under = vbus_valid && (vbus_sample < bus_lo_th);
  wire bus_inwin = vbus_valid && !bus_over && !bus_under;

  wire [RCNT_W-1:0] len_eff = (recycle_len == '0) ? RCNT_W'(1) : recycle_len;
  wire run_done = ({1'b0, rcnt_q} + (RCNT_W+1)'(1)) >= {1'b0, len_eff};
  wire recover  = (state_q == ST_ERR) && (lamp_insert || (lost_q && vin_acc));

  always_comb begin
    if (ocp_flag)                          fault_sel = F_OCP;
    else if (vin_over)                     fault_sel = F_VIN;
    else if (bus_over)                     fault_sel = F_BHI;
    else if (bus_under && state_q == ST_RUN) fault_sel = F_BLO;
    else if (ton_sat_err)                  fault_sel = F_TON;
    else if (ballast_err)                  fault_sel = F_BAL;
    else                                   fault_sel = F_NONE;
  end

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    case (state_q)
      ST_INIT:  if (icnt_q == ICW'(INIT_CYCLES - 1)) state_d = ST_CHECK;
      ST_CHECK: begin
        if (vin_over) begin
          state_d = ST_ERR;
          fault_d = F_VIN;
        end else if (vin_inwin) begin
          state_d = ST_START;
        end
      end
      ST_START, ST_RUN: begin
        if (fault_sel != F_NONE) begin
          state_d = ST_ERR;
          fault_d = fault_sel;
        end else if (state_q == ST_START && bus_inwin) begin
          state_d = ST_RUN;
        end
      end
      ST_ERR: if (recover) begin
        state_d = ST_INIT;
        fault_d = F_NONE;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      fault_q <= F_NONE;
      icnt_q  <= '0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      icnt_q  <= (state_q == ST_INIT) ? icnt_q + ICW'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      lost_q <= 1'b0;
    end else if (state_q != ST_ERR) begin
      rcnt_q <= '0;
      lost_q <= 1'b0;
    end else if (vin_low) begin
      if (rcnt_q != '1) rcnt_q <= rcnt_q + RCNT_W'(1);
      if (run_done) lost_q <= 1'b1;
    end else if (vin_valid) begin
      rcnt_q <= '0;
    end
  end

  assign pwm_en     = switching && !ocp_flag;
  assign state_code = state_q;
  assign fault_code = fault_q;

  assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) != ST_START) |-> ($past(state_q) == ST_CHECK && $past(vin_inwin)));

  assert_ocp_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_flag |-> !pwm_en);

  assert_ocp_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (switching && ocp_flag) |=> (state_q == ST_ERR && fault_q == F_OCP));

  assert_run_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_START);

  assert_stop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR) |-> (fault_q != F_NONE && !pwm_en));

  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR && !recover) |=> (state_q == ST_ERR && $stable(fault_q)));

  assert_cause_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_ERR) |-> fault_q == F_NONE);

endmodule

// File: tb/pfc_supervisor_tb.sv
module pfc_supervisor_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic vin_valid = 0, vbus_valid = 0;
  logic [9:0] vin_sample = 0, vbus_sample = 0;
  logic [9:0] vin_lo_th = 10'd300, vin_hi_th = 10'd700, vin_gone_th = 10'd50;
  logic [9:0] bus_lo_th = 10'd400, bus_hi_th = 10'd600;
  logic [7:0] recycle_len = 8'd3;
  logic ocp_flag = 0, ton_sat_err = 0, ballast_err = 0, lamp_insert = 0;
  logic pwm_en;
  logic [2:0] state_code, fault_code;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pfc_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .vin_valid(vin_valid), .vin_sample(vin_sample),
    .vbus_valid(vbus_valid), .vbus_sample(vbus_sample), .vin_lo_th(vin_lo_th),
    .vin_hi_th(vin_hi_th), .vin_gone_th(vin_gone_th), .bus_lo_th(bus_lo_th),
    .bus_hi_th(bus_hi_th), .recycle_len(recycle_len), .ocp_flag(ocp_flag),
    .ton_sat_err(ton_sat_err), .ballast_err(ballast_err), .lamp_insert(lamp_insert),
    .pwm_en(pwm_en), .state_code(state_code), .fault_code(fault_code));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_vin(int v);
    vin_sample = 10'(v); vin_valid = 1; tick(); vin_valid = 0;
  endtask

  task automatic send_bus(int v);
    vbus_sample = 10'(v); vbus_valid = 1; tick(); vbus_valid = 0;
  endtask

  task automatic lamp();
    lamp_insert = 1; tick(); lamp_insert = 0;
  endtask

  task automatic wait_check();
    for (int i = 0; i < 20 && state_code != 3'd1; i++) tick();
  endtask

  task automatic to_run();
    if (state_code == 3'd4) lamp();
    wait_check();
    send_vin(500);
    send_bus(500);
  endtask

  task automatic t_reset();
    chk("R1 reset state", state_code, 0);
    chk("R1 reset fault", fault_code, 0);
    chk("R1 reset pwm", pwm_en, 0);
    rst_n = 1;
    for (int i = 0; i < 15; i++) tick();
    chk("R1 still init", state_code, 0);
    tick();
    chk("R1 to check", state_code, 1);
  endtask

  task automatic t_check_pass();
    send_vin(200);
    chk("R2 low keeps check", state_code, 1);
    chk("R2 no pwm in check", pwm_en, 0);
    send_vin(300);
    chk("R2 start", state_code, 2);
    chk("R2 pwm on", pwm_en, 1);
  endtask

  task automatic t_start_run();
    send_bus(300);
    chk("R5 low bus stays start", state_code, 2);
    send_bus(600);
    chk("R5 run", state_code, 3);
  endtask

  task automatic t_ocp_hold();
    ocp_flag = 1; #1;
    chk("R4 pwm gated", pwm_en, 0);
    tick(); ocp_flag = 0;
    chk("R4 stopped", state_code, 4);
    chk("R4 fault", fault_code, 1);
    send_vin(500); send_bus(500); tick();
    chk("R10 held state", state_code, 4);
    chk("R10 held fault", fault_code, 1);
    chk("R10 pwm off", pwm_en, 0);
    lamp();
    chk("R11 restart", state_code, 0);
    chk("R11 fault cleared", fault_code, 0);
  endtask

  task automatic t_bus_faults();
    to_run(); send_bus(601);
    chk("R6 bus high", fault_code, 3);
    to_run(); send_bus(399);
    chk("R6 bus low", fault_code, 4);
    wait_check(); lamp(); wait_check(); send_vin(500); send_bus(601);
    chk("R5 start bus high", fault_code, 3);
  endtask

  task automatic t_other_faults();
    to_run(); send_vin(701);
    chk("R7 mains high", fault_code, 2);
    to_run(); ton_sat_err = 1; tick(); ton_sat_err = 0;
    chk("R8 ton sat", fault_code, 5);
    to_run(); ballast_err = 1; tick(); ballast_err = 0;
    chk("R8 ballast", fault_code, 6);
    lamp(); wait_check(); send_vin(800);
    chk("R3 wrong mains state", state_code, 4);
    chk("R3 wrong mains fault", fault_code, 2);
  endtask

  task automatic t_priority();
    to_run(); ocp_flag = 1; ballast_err = 1; tick(); ocp_flag = 0; ballast_err = 0;
    chk("R9 ocp over ballast", fault_code, 1);
    to_run(); ton_sat_err = 1; vbus_sample = 10'd100; vbus_valid = 1; tick();
    ton_sat_err = 0; vbus_valid = 0;
    chk("R9 bus low over ton", fault_code, 4);
    to_run(); vin_sample = 10'd900; vin_valid = 1; vbus_sample = 10'd900; vbus_valid = 1; tick();
    vin_valid = 0; vbus_valid = 0;
    chk("R9 mains over bus", fault_code, 2);
  endtask

  task automatic t_recycle();
    to_run();
    lamp_insert = 1; tick(); lamp_insert = 0;
    chk("R11 insert ignored in run", state_code, 3);
    ballast_err = 1; tick(); ballast_err = 0;
    send_vin(10); send_vin(10); send_vin(100); send_vin(10);
    send_vin(500);
    chk("R12 broken run stays stopped", state_code, 4);
    chk("R12 cause kept", fault_code, 6);
    send_vin(10); send_vin(10); send_vin(10);
    chk("R12 lost but waiting", state_code, 4);
    send_vin(200);
    chk("R12 below accept stays", state_code, 4);
    send_vin(400);
    chk("R12 recycle restart", state_code, 0);
    chk("R12 fault cleared", fault_code, 0);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        t_reset(); t_check_pass(); t_start_run(); t_ocp_hold();
        t_bus_faults(); t_other_faults(); t_priority(); t_recycle();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule